// File: doc/BRIEF.md
# Destination Ring Receive Writer

This block is the receive half of a descriptor-driven copy engine. Software gives it empty buffers by placing descriptors in a power-of-two ring in descriptor memory. Word 0 of each descriptor holds the buffer address. Software then moves a write index forward through a small register port. When a transfer arrives on the input stream, the block takes the buffer at its read index, reads that descriptor's address and stores each beat of the transfer into the buffer. It then writes a completion word back into the same descriptor and moves its read index forward by one.

A completion word with a byte count of zero means the entry is not finished yet. Software clears the count of any entry it gives back to the ring. The block clears every descriptor word of the ring when the ring size is programmed. Because of these two rules, a stale or uninitialised entry never looks finished. When no buffer is posted, the input stream is held off. Each completion raises a one-cycle event for the interrupt logic.

Top module: `drw_dest_ring_writer`

## Requirements
- R1: The ring holds 2^n entries, where n is written to register select 1 and limited to IDX_W. Read and write indices wrap modulo the entry count: after entry 2^n-1 the read index returns to 0.
- R2: The registers are: select 0 is the descriptor base byte address (low 3 bits forced to 0), select 2 is the write index, and select 3 bit 0 is the swap enable. A write to select 1 resets both indices to 0 and then writes zero to all 2*2^n descriptor words starting at the base, one word per cycle, leaving words beyond the ring untouched.
- R3: While the read index equals the write index, in_ready_o stays low, no transfer is started and nothing is written.
- R4: Entry i's descriptor sits at base+8*i. Its word 0 gives the buffer address, and beat k of a transfer is written to buffer+4*k.
- R5: Word 1 of the descriptor, at base+8*i+4, receives the completion word. Bits [15:0] hold the bytes stored, bit 16 the swap flag, bit 17 the truncation flag, and bits [31:24] the transfer ID taken from in_meta_i on the last beat. The byte count of a completion is never zero.
- R6: If swap enable is set when a transfer starts, every stored word has its four bytes reversed and bit 16 of the completion word is set. Otherwise data is stored unchanged and bit 16 is clear.
- R7: Beats that would pass BUF_BYTES are accepted but not written. The count stops at BUF_BYTES and bit 17 is set.
- R8: All beats up to and including the one with in_last_i go to one buffer and produce exactly one completion.
- R9: The completion word is written to memory in the cycle before the read index advances. The read index moves forward by exactly one, and copy_done_o is high for one cycle together with the new index.
- R10: After reset the read index is 0 and in_ready_o, copy_done_o and all write strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| rd_idx_o | output | IDX_W | Current read index |
| desc_rd_en_o | output | 1 | Descriptor read request |
| desc_rd_addr_o | output | 32 | Descriptor read byte address |
| desc_rd_data_i | input | 32 | Descriptor read data, one cycle after the request |
| desc_wr_en_o | output | 1 | Descriptor write strobe |
| desc_wr_addr_o | output | 32 | Descriptor write byte address |
| desc_wr_data_o | output | 32 | Descriptor write data |
| dat_we_o | output | 1 | Buffer data write strobe |
| dat_addr_o | output | 32 | Buffer data byte address |
| dat_wdata_o | output | 32 | Buffer data word |
| in_valid_i | input | 1 | Stream beat valid |
| in_ready_o | output | 1 | Stream beat accepted |
| in_data_i | input | 32 | Stream beat data |
| in_last_i | input | 1 | Final beat of a transfer |
| in_meta_i | input | 8 | Transfer ID, sampled on the final beat |
| copy_done_o | output | 1 | One-cycle completion event |

## Verification
Transfers of one, two, three and six beats are sent. This separates the single-beat case from gathering several beats into one buffer, and an in-range length from one cut off at the buffer limit. The same one-beat traffic is run with swap enable on and off, so a byte reversal cannot hide behind an unchanged flag. A stream that is held valid with no buffer posted shows the back-pressure. A run of five transfers through a four-entry ring makes the read index wrap back through zero. A ring clear over descriptor words preloaded with garbage shows that exactly the ring's own words are zeroed.

// File: rtl/drw_pkg.sv
`timescale 1ns/1ps
package drw_pkg;

    localparam int BEAT_BYTES = 4;
    localparam int META_W     = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_FETCH,
        ST_STREAM,
        ST_WRBACK,
        ST_ADVANCE
    } eng_state_t;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_SIZE = 2'd1,
        SEL_WIDX = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_t;

    // Layout of descriptor word 1 after completion
    typedef struct packed {
        logic [META_W-1:0] xfer_id;
        logic [5:0]        rsvd;
        logic              trunc;
        logic              swapped;
        logic [15:0]       nbytes;
    } cmpl_word_t;

    function automatic logic [31:0] swap_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/drw_ring_regs.sv
`timescale 1ns/1ps
module drw_ring_regs
    import drw_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    input  logic             adv_i,
    output logic [31:0]      base_o,
    output logic [IDX_W-1:0] mask_o,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic             swap_en_o,
    output logic             clr_req_o,
    output logic             done_o
);

    logic [31:0]      size_clip;
    logic [31:0]      mask_full;
    logic [IDX_W-1:0] mask_new;

    always_comb begin
        size_clip = (reg_wdata > 32'(IDX_W)) ? 32'(IDX_W) : reg_wdata;
        mask_full = (32'd1 << size_clip) - 32'd1;
        mask_new  = mask_full[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_o    <= '0;
            mask_o    <= '1;
            rd_idx_o  <= '0;
            wr_idx_o  <= '0;
            swap_en_o <= 1'b0;
            clr_req_o <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            clr_req_o <= 1'b0;
            done_o    <= 1'b0;
            if (adv_i) begin
                rd_idx_o <= (rd_idx_o + 1'b1) & mask_o;
                done_o   <= 1'b1;
            end
            if (reg_we) begin
                case (reg_sel_t'(reg_sel))
                    SEL_BASE: base_o <= {reg_wdata[31:3], 3'b000};
                    SEL_SIZE: begin
                        mask_o    <= mask_new;
                        rd_idx_o  <= '0;
                        wr_idx_o  <= '0;
                        clr_req_o <= 1'b1;
                    end
                    SEL_WIDX: wr_idx_o  <= reg_wdata[IDX_W-1:0] & mask_o;
                    SEL_CTRL: swap_en_o <= reg_wdata[0];
                    default:  ;
                endcase
            end
        end
    end

    AST_IDX_MASKED: assert property (@(posedge clk) disable iff (rst)
        ((rd_idx_o | wr_idx_o) & ~mask_o) == '0); // R1

endmodule

// File: rtl/drw_rx_engine.sv
`timescale 1ns/1ps
module drw_rx_engine
    import drw_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int BUF_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       base_i,
    input  logic [IDX_W-1:0]  mask_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic              swap_en_i,
    input  logic              clr_req_i,
    output logic              adv_o,
    output logic              desc_rd_en_o,
    output logic [31:0]       desc_rd_addr_o,
    input  logic [31:0]       desc_rd_data_i,
    output logic              desc_wr_en_o,
    output logic [31:0]       desc_wr_addr_o,
    output logic [31:0]       desc_wr_data_o,
    output logic              dat_we_o,
    output logic [31:0]       dat_addr_o,
    output logic [31:0]       dat_wdata_o,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [31:0]       in_data_i,
    input  logic              in_last_i,
    input  logic [META_W-1:0] in_meta_i
);

    localparam int CNT_W = $clog2(BUF_BYTES + 1);

    eng_state_t        state;
    logic [31:0]       buf_addr;
    logic [CNT_W-1:0]  byte_cnt;
    logic              trunc_q;
    logic              swap_q;
    logic [META_W-1:0] meta_q;
    logic [IDX_W:0]    clr_cnt;

    logic              avail;
    logic              hs;
    logic              room;
    logic [31:0]       desc_addr;
    logic [IDX_W:0]    clr_last;
    cmpl_word_t        cmpl;

    always_comb begin
        avail     = (rd_idx_i != wr_idx_i);
        desc_addr = base_i + 32'({rd_idx_i, 3'b000});
        clr_last  = {mask_i, 1'b1};
        room      = (32'(byte_cnt) + 32'(BEAT_BYTES)) <= 32'(BUF_BYTES);

        in_ready_o = (state == ST_STREAM);
        hs         = in_valid_i && in_ready_o;

        dat_we_o    = hs && room;
        dat_addr_o  = buf_addr + 32'(byte_cnt);
        dat_wdata_o = swap_q ? swap_bytes(in_data_i) : in_data_i;

        desc_rd_en_o   = (state == ST_IDLE) && in_valid_i && avail && !clr_req_i;
        desc_rd_addr_o = desc_addr;

        cmpl.xfer_id = meta_q;
        cmpl.rsvd    = '0;
        cmpl.trunc   = trunc_q;
        cmpl.swapped = swap_q;
        cmpl.nbytes  = 16'(byte_cnt);

        desc_wr_en_o = (state == ST_CLEAR) || (state == ST_WRBACK);
        if (state == ST_CLEAR) begin
            desc_wr_addr_o = base_i + 32'({clr_cnt, 2'b00});
            desc_wr_data_o = '0;
        end else begin
            desc_wr_addr_o = desc_addr + 32'd4;
            desc_wr_data_o = cmpl;
        end

        adv_o = (state == ST_ADVANCE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            buf_addr <= '0;
            byte_cnt <= '0;
            trunc_q  <= 1'b0;
            swap_q   <= 1'b0;
            meta_q   <= '0;
            clr_cnt  <= '0;
        end else if (clr_req_i) begin
            state   <= ST_CLEAR;
            clr_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: if (desc_rd_en_o) begin
                    state    <= ST_FETCH;
                    swap_q   <= swap_en_i;
                    byte_cnt <= '0;
                    trunc_q  <= 1'b0;
                end
                ST_FETCH: begin
                    buf_addr <= desc_rd_data_i;
                    state    <= ST_STREAM;
                end
                ST_STREAM: if (hs) begin
                    if (room) byte_cnt <= byte_cnt + CNT_W'(BEAT_BYTES);
                    else      trunc_q  <= 1'b1;
                    if (in_last_i) begin
                        meta_q <= in_meta_i;
                        state  <= ST_WRBACK;
                    end
                end
                ST_WRBACK:  state <= ST_ADVANCE;
                ST_ADVANCE: state <= ST_IDLE;
                ST_CLEAR: begin
                    if (clr_cnt == clr_last) state <= ST_IDLE;
                    else                     clr_cnt <= clr_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_WB_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRBACK) |-> (desc_wr_data_o[15:0] != 16'd0)); // R5

    AST_WRITE_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
        dat_we_o |-> (in_valid_i && in_ready_o)); // R4

endmodule

// File: rtl/drw_dest_ring_writer.sv
`timescale 1ns/1ps
module drw_dest_ring_writer
    import drw_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int BUF_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [IDX_W-1:0]  rd_idx_o,
    output logic              desc_rd_en_o,
    output logic [31:0]       desc_rd_addr_o,
    input  logic [31:0]       desc_rd_data_i,
    output logic              desc_wr_en_o,
    output logic [31:0]       desc_wr_addr_o,
    output logic [31:0]       desc_wr_data_o,
    output logic              dat_we_o,
    output logic [31:0]       dat_addr_o,
    output logic [31:0]       dat_wdata_o,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [31:0]       in_data_i,
    input  logic              in_last_i,
    input  logic [META_W-1:0] in_meta_i,
    output logic              copy_done_o
);

    logic [31:0]      base;
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] wr_idx;
    logic             swap_en;
    logic             clr_req;
    logic             adv;
    logic             size_wr;

    assign size_wr = reg_we && (reg_sel == SEL_SIZE);

    drw_ring_regs #(.IDX_W(IDX_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .adv_i     (adv),
        .base_o    (base),
        .mask_o    (mask),
        .rd_idx_o  (rd_idx_o),
        .wr_idx_o  (wr_idx),
        .swap_en_o (swap_en),
        .clr_req_o (clr_req),
        .done_o    (copy_done_o)
    );

    drw_rx_engine #(.IDX_W(IDX_W), .BUF_BYTES(BUF_BYTES)) eng_i (
        .clk            (clk),
        .rst            (rst),
        .base_i         (base),
        .mask_i         (mask),
        .rd_idx_i       (rd_idx_o),
        .wr_idx_i       (wr_idx),
        .swap_en_i      (swap_en),
        .clr_req_i      (clr_req),
        .adv_o          (adv),
        .desc_rd_en_o   (desc_rd_en_o),
        .desc_rd_addr_o (desc_rd_addr_o),
        .desc_rd_data_i (desc_rd_data_i),
        .desc_wr_en_o   (desc_wr_en_o),
        .desc_wr_addr_o (desc_wr_addr_o),
        .desc_wr_data_o (desc_wr_data_o),
        .dat_we_o       (dat_we_o),
        .dat_addr_o     (dat_addr_o),
        .dat_wdata_o    (dat_wdata_o),
        .in_valid_i     (in_valid_i),
        .in_ready_o     (in_ready_o),
        .in_data_i      (in_data_i),
        .in_last_i      (in_last_i),
        .in_meta_i      (in_meta_i)
    );

    AST_READY_NEEDS_BUF: assert property (@(posedge clk) disable iff (rst)
        in_ready_o |-> (rd_idx_o != wr_idx)); // R3

    AST_WB_BEFORE_ADV: assert property (@(posedge clk) disable iff (rst)
        ((rd_idx_o != $past(rd_idx_o)) && !$past(size_wr))
        |-> ($past(desc_wr_en_o, 2) && ($past(desc_wr_data_o[15:0], 2) != 16'd0))); // R9

    AST_DONE_STEP: assert property (@(posedge clk) disable iff (rst)
        copy_done_o |-> (rd_idx_o == (IDX_W'($past(rd_idx_o) + 1'b1) & mask))); // R9

endmodule

// File: tb/drw_dest_ring_writer_tb_top.sv
`timescale 1ns/1ps
module drw_dest_ring_writer_tb_top;

    localparam int IDX_W = 4;
    localparam int BUF_BYTES = 16;
    localparam logic [31:0] RING_BASE = 32'h40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [IDX_W-1:0] rd_idx;
    logic        desc_rd_en;
    logic [31:0] desc_rd_addr;
    logic [31:0] desc_rd_data = '0;
    logic        desc_wr_en;
    logic [31:0] desc_wr_addr;
    logic [31:0] desc_wr_data;
    logic        dat_we;
    logic [31:0] dat_addr;
    logic [31:0] dat_wdata;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic [7:0]  in_meta = '0;
    logic        copy_done;

    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_data = '0;
    logic [31:0] dmem [0:63];

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    bit finished = 0;

    logic [31:0] exp_addr_q [$];
    logic [31:0] exp_data_q [$];
    string       exp_tag_q  [$];
    int          cmp_idx_q  [$];
    logic [31:0] cmp_word_q [$];
    string       cmp_tag_q  [$];

    always #10 clk = ~clk;

    drw_dest_ring_writer #(.IDX_W(IDX_W), .BUF_BYTES(BUF_BYTES)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .rd_idx_o(rd_idx), .desc_rd_en_o(desc_rd_en), .desc_rd_addr_o(desc_rd_addr),
        .desc_rd_data_i(desc_rd_data), .desc_wr_en_o(desc_wr_en), .desc_wr_addr_o(desc_wr_addr),
        .desc_wr_data_o(desc_wr_data), .dat_we_o(dat_we), .dat_addr_o(dat_addr),
        .dat_wdata_o(dat_wdata), .in_valid_i(in_valid), .in_ready_o(in_ready),
        .in_data_i(in_data), .in_last_i(in_last), .in_meta_i(in_meta), .copy_done_o(copy_done)
    );

    // Descriptor memory model, registered read
    always @(posedge clk) begin
        if (desc_rd_en) desc_rd_data <= dmem[desc_rd_addr[7:2]];
        if (desc_wr_en) dmem[desc_wr_addr[7:2]] <= desc_wr_data;
        if (host_we)    dmem[host_addr] <= host_data;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare buffer writes and completions against the scoreboard
    always @(negedge clk) begin
        if (!rst && dat_we) begin
            if (exp_addr_q.size() == 0) begin
                check(0, "R3 unexpected data write", dat_addr, 32'h0);
            end else begin
                logic [31:0] ea, ed;
                string t;
                ea = exp_addr_q.pop_front();
                ed = exp_data_q.pop_front();
                t  = exp_tag_q.pop_front();
                check(dat_addr == ea, {t, " address"}, dat_addr, ea);
                check(dat_wdata == ed, {t, " data"}, dat_wdata, ed);
            end
        end
        if (!rst && copy_done) begin
            done_cnt++;
            if (cmp_idx_q.size() == 0) begin
                check(0, "R8 unexpected completion", 32'(rd_idx), 32'h0);
            end else begin
                int ci;
                logic [31:0] cw;
                string t;
                ci = cmp_idx_q.pop_front();
                cw = cmp_word_q.pop_front();
                t  = cmp_tag_q.pop_front();
                check(32'(rd_idx) == 32'((ci + 1) % 4), "R9 read index step", 32'(rd_idx), 32'((ci + 1) % 4));
                check(dmem[6'(16 + 2*ci + 1)] == cw, {t, " completion word"}, dmem[6'(16 + 2*ci + 1)], cw);
            end
        end
    end

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] val);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    task automatic host_write(input int word, input logic [31:0] val);
        @(posedge clk); #2;
        host_we = 1'b1; host_addr = 6'(word); host_data = val;
        @(posedge clk); #2;
        host_we = 1'b0;
    endtask

    // Post buffer at entry idx, clear its count, advance write index
    task automatic post(input int idx, input logic [31:0] buf_addr);
        host_write(16 + 2*idx, buf_addr);
        host_write(16 + 2*idx + 1, 32'h0);
        reg_write(2'd2, 32'((idx + 1) % 4));
    endtask

    // Driver: push expected writes and completion, then stream the beats
    task automatic send(input int idx, input logic [31:0] buf_addr, input int nbeats,
                        input logic [31:0] dbase, input logic [7:0] meta, input bit swp,
                        input string tag);
        int stored = 0;
        bit trunc = 0;
        for (int k = 0; k < nbeats; k++) begin
            if ((k + 1) * 4 <= BUF_BYTES) begin
                exp_addr_q.push_back(buf_addr + 32'(4*k));
                exp_data_q.push_back(swp ? {dbase[7:0]+8'(k), dbase[15:8], dbase[23:16], dbase[31:24]}
                                         : dbase + 32'(k));
                exp_tag_q.push_back(tag);
                stored += 4;
            end else begin
                trunc = 1;
            end
        end
        cmp_idx_q.push_back(idx);
        cmp_word_q.push_back({meta, 6'b0, trunc, swp, 16'(stored)});
        cmp_tag_q.push_back(tag);
        for (int k = 0; k < nbeats; k++) begin
            bit hs = 0;
            @(posedge clk); #2;
            in_valid = 1'b1;
            in_data  = dbase + 32'(k);
            in_last  = (k == nbeats - 1);
            in_meta  = (k == nbeats - 1) ? meta : 8'hEE;
            for (int w = 0; w < 200 && !hs; w++) begin
                @(negedge clk);
                hs = in_ready;
                if (!hs) begin
                    @(posedge clk); #2;
                end
            end
        end
        @(posedge clk); #2;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_done(input int target);
        for (int w = 0; w < 300 && done_cnt < target; w++) @(negedge clk);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_sim();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(rd_idx == '0, "R10 read index", 32'(rd_idx), 32'h0);
        check(!in_ready && !copy_done && !dat_we && !desc_wr_en, "R10 strobes low",
              {28'h0, in_ready, copy_done, dat_we, desc_wr_en}, 32'h0);

        // R2: garbage, then program ring and check the clear sweep
        for (int i = 0; i <= 8; i++) host_write(16 + i, 32'hDEAD0000 + 32'(i));
        reg_write(2'd0, RING_BASE);
        reg_write(2'd1, 32'd2);
        repeat (14) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 8; i++)
            check(dmem[16 + i] == 32'h0, "R2 ring word cleared", dmem[16 + i], 32'h0);
        check(dmem[24] == 32'hDEAD0008, "R2 word past ring kept", dmem[24], 32'hDEAD0008);

        // R3: stream valid with nothing posted is held off
        @(posedge clk); #2;
        in_valid = 1'b1; in_data = 32'h55AA55AA; in_last = 1'b1;
        begin
            bit seen = 0;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (in_ready || desc_rd_en) seen = 1;
            end
            check(!seen, "R3 no buffer back-pressure", 32'(seen), 32'h0);
        end
        @(posedge clk); #2;
        in_valid = 1'b0; in_last = 1'b0;

        // R4 / R8: three-beat gather into entry 0
        post(0, 32'h1000);
        send(0, 32'h1000, 3, 32'hA0000000, 8'h21, 0, "R4 R8 gather");
        wait_done(1);
        repeat (5) @(negedge clk);
        check(done_cnt == 1, "R8 single completion", 32'(done_cnt), 32'd1);

        // R6: byte swap enabled, single beat into entry 1
        reg_write(2'd3, 32'd1);
        post(1, 32'h2000);
        send(1, 32'h2000, 1, 32'h11223344, 8'h5A, 1, "R6 swap");
        wait_done(2);
        reg_write(2'd3, 32'd0);

        // R7: six beats into a 16-byte buffer at entry 2
        post(2, 32'h3000);
        send(2, 32'h3000, 6, 32'hC0000000, 8'h33, 0, "R7 truncate");
        wait_done(3);

        // R1: wrap through entry 3 back to entry 0
        post(3, 32'h4000);
        send(3, 32'h4000, 1, 32'hD0000000, 8'h44, 0, "R5 single");
        wait_done(4);
        check(rd_idx == 4'd0, "R1 wrap to zero", 32'(rd_idx), 32'h0);
        post(0, 32'h5000);
        send(0, 32'h5000, 2, 32'hE0000000, 8'h55, 0, "R1 after wrap");
        wait_done(5);
        repeat (5) @(negedge clk);
        check(rd_idx == 4'd1, "R1 index after wrap", 32'(rd_idx), 32'h1);
        check(done_cnt == 5, "R9 completion count", 32'(done_cnt), 32'd5);
        check(exp_addr_q.size() == 0 && cmp_idx_q.size() == 0, "R4 scoreboard drained",
              32'(exp_addr_q.size() + cmp_idx_q.size()), 32'h0);

        finished = 1;
        finish_sim();
    end

endmodule